// File: doc/BRIEF.md
# DRAM Reset and ZQ Calibration Sequencer

This controller-side block owns the active-low reset line of an external DRAM and plans its impedance (ZQ) calibration commands. When power-good comes up, it holds the DRAM in reset for a programmable number of clocks. It then releases reset and at once issues the long calibration that belongs to initialization. It reports the calibration window through a busy flag, and it raises an init-done flag once that window has elapsed.

After initialization, the surrounding controller can ask for a short calibration or an extra long calibration. Requests are latched and wait until the DRAM is reported idle and no window is running. When a long and a short request are both waiting, the long one goes first. The initialization long window and a later long window have separate lengths.

A warm reset can also be requested. It pulls reset low for a separately programmed, shorter hold and then repeats the full initialization, including the initialization-length long calibration. Power-good acts as the asynchronous master reset of the sequencer itself.

Top module: `dram_rstcal_seq`

## Requirements
- R1: While power-good is low, dram_rst_n, cal_busy, init_done and cal_cmd are all 0. After power-good rises, dram_rst_n stays low and is released at the PWR_HOLD_CLKS-th rising clock edge.
- R2: In the first cycle with dram_rst_n high, cal_cmd carries the long code 2'b01 for exactly one cycle. cal_busy is high for INIT_ZQ_CLKS cycles, counting that command cycle. No other command appears inside the window.
- R3: init_done is 0 until the initialization window ends. It is 1 from the first cycle in which cal_busy is low again.
- R4: Calibration requests that arrive before init_done is 1 are discarded and never produce a command.
- R5: After initialization, with the DRAM idle, a short request held for one cycle gives the short code 2'b10 on cal_cmd in the second cycle after the request cycle. cal_busy then lasts SHORT_ZQ_CLKS cycles.
- R6: After initialization, a long request gives code 2'b01 with the same latency. cal_busy then lasts LONG_ZQ_CLKS cycles, which is shorter than the initialization window.
- R7: A request that arrives while dram_idle is low is kept pending. Its command is issued in the cycle after the first clock edge at which dram_idle is sampled high.
- R8: When a long and a short request are both pending, the long command goes out first. The short command follows one cycle after cal_busy falls.
- R9: After initialization, a command is issued only if dram_idle was high at the clock edge that issued it.
- R10: A warm reset request after initialization drives dram_rst_n low from the next cycle for WARM_HOLD_CLKS cycles. It clears init_done and discards pending requests. It then repeats the initialization calibration of R2 and R3.
- R11: A warm reset request made before init_done is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| pwr_good | input | 1 | Power-good; low resets the sequencer asynchronously |
| warm_rst_req | input | 1 | Request a warm reset and full re-initialization |
| dram_idle | input | 1 | High when the DRAM can accept a calibration |
| zq_long_req | input | 1 | Request a long calibration |
| zq_short_req | input | 1 | Request a short calibration |
| cal_cmd | output | 2 | Calibration command: 00 none, 01 long, 10 short |
| dram_rst_n | output | 1 | Active-low DRAM reset |
| cal_busy | output | 1 | High for the whole calibration window |
| init_done | output | 1 | High once initialization calibration completes |

## Verification
The bench uses a power-up hold of 40 clocks, a warm hold of 6, an initialization window of 24, a later long window of 12 and a short window of 5. With these values, a power-up, a warm reset and every calibration variant each fit in a few dozen cycles. Because all five numbers differ, a swapped window length or hold time appears as a wrong count at the ports. The queue and priority cases are reached by holding dram_idle low while requests stack up.

// File: rtl/rstcal_pkg.sv
package rstcal_pkg;

   typedef enum logic [1:0] {
      CMD_NOP      = 2'b00,
      CMD_ZQ_LONG  = 2'b01,
      CMD_ZQ_SHORT = 2'b10
   } zq_cmd_e;

   typedef enum logic [1:0] {
      ST_HOLD,
      ST_ISSUE,
      ST_CAL,
      ST_READY
   } seq_state_e;

   // request slot indices; lower index wins arbitration
   localparam int KIND_LONG  = 0;
   localparam int KIND_SHORT = 1;
   localparam int NUM_KINDS  = 2;

endpackage

// File: rtl/rstcal_down_cnt.sv
module rstcal_down_cnt #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         at_zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          cnt <= W'(RST_VAL);
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign at_zero = (cnt == '0);

endmodule

// File: rtl/rstcal_req_queue.sv
module rstcal_req_queue #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           arst_n,
   input  logic           accept,
   input  logic           flush,
   input  logic [NUM-1:0] req,
   input  logic [NUM-1:0] grant,
   output logic [NUM-1:0] pend,
   output logic [NUM-1:0] pick,
   output logic           any
);

   for (genvar i = 0; i < NUM; i++) begin : g_slot
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)                  pend[i] <= 1'b0;
         else if (flush)               pend[i] <= 1'b0;
         else if (accept && req[i])    pend[i] <= 1'b1;
         else if (grant[i])            pend[i] <= 1'b0;
      end
   end

   always_comb begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < NUM; i++) begin
         pick[i] = pend[i] && !taken;
         taken   = taken || pend[i];
      end
   end

   assign any = |pend;

   // R4: no slot becomes pending while requests are not accepted
   a_r4_no_set_before_init: assert property (@(posedge clk) disable iff (!arst_n)
      (!accept) |=> ((pend & ~$past(pend)) == '0));

endmodule

// File: rtl/dram_rstcal_seq.sv
module dram_rstcal_seq
   import rstcal_pkg::*;
#(
   parameter int PWR_HOLD_CLKS  = 160000,
   parameter int WARM_HOLD_CLKS = 80,
   parameter int INIT_ZQ_CLKS   = 512,
   parameter int LONG_ZQ_CLKS   = 256,
   parameter int SHORT_ZQ_CLKS  = 64
) (
   input  logic       clk,
   input  logic       pwr_good,
   input  logic       warm_rst_req,
   input  logic       dram_idle,
   input  logic       zq_long_req,
   input  logic       zq_short_req,
   output logic [1:0] cal_cmd,
   output logic       dram_rst_n,
   output logic       cal_busy,
   output logic       init_done
);

   localparam int MAX_A = (PWR_HOLD_CLKS > WARM_HOLD_CLKS) ? PWR_HOLD_CLKS : WARM_HOLD_CLKS;
   localparam int MAX_B = (INIT_ZQ_CLKS > LONG_ZQ_CLKS) ? INIT_ZQ_CLKS : LONG_ZQ_CLKS;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAXV  = (MAX_C > SHORT_ZQ_CLKS) ? MAX_C : SHORT_ZQ_CLKS;
   localparam int CNT_W = $clog2(MAXV + 1);

   if (PWR_HOLD_CLKS < 2 || WARM_HOLD_CLKS < 1) begin : g_bad_hold
      $error("hold lengths too small");
   end
   if (INIT_ZQ_CLKS < 2 || LONG_ZQ_CLKS < 2 || SHORT_ZQ_CLKS < 2) begin : g_bad_win
      $error("calibration windows must be at least 2 clocks");
   end

   seq_state_e           state, state_d;
   zq_cmd_e              kind, kind_d;
   logic                 done_q, done_d;
   logic                 load, cnt_zero;
   logic [CNT_W-1:0]     load_val;
   logic                 warm_go;
   logic [NUM_KINDS-1:0] req_vec, grant_vec, pend, pick;
   logic                 any_pend;

   assign warm_go = warm_rst_req && done_q;

   assign req_vec[KIND_LONG]  = zq_long_req;
   assign req_vec[KIND_SHORT] = zq_short_req;

   rstcal_req_queue #(.NUM(NUM_KINDS)) u_queue (
      .clk    (clk),
      .arst_n (pwr_good),
      .accept (done_q),
      .flush  (warm_go),
      .req    (req_vec),
      .grant  (grant_vec),
      .pend   (pend),
      .pick   (pick),
      .any    (any_pend)
   );

   rstcal_down_cnt #(.W(CNT_W), .RST_VAL(PWR_HOLD_CLKS - 1)) u_cnt (
      .clk      (clk),
      .arst_n   (pwr_good),
      .load     (load),
      .load_val (load_val),
      .at_zero  (cnt_zero)
   );

   assign grant_vec = (state == ST_READY && dram_idle && any_pend && !warm_go)
                      ? pick : '0;

   always_comb begin
      state_d  = state;
      kind_d   = kind;
      done_d   = done_q;
      load     = 1'b0;
      load_val = '0;
      if (warm_go) begin
         state_d  = ST_HOLD;
         done_d   = 1'b0;
         load     = 1'b1;
         load_val = CNT_W'(WARM_HOLD_CLKS - 1);
      end else begin
         unique case (state)
            ST_HOLD: if (cnt_zero) begin
               state_d  = ST_ISSUE;
               kind_d   = CMD_ZQ_LONG;
               load     = 1'b1;
               load_val = CNT_W'(INIT_ZQ_CLKS - 1);
            end
            ST_ISSUE: state_d = ST_CAL;
            ST_CAL: if (cnt_zero) begin
               state_d = ST_READY;
               done_d  = 1'b1;
            end
            ST_READY: if (|grant_vec) begin
               state_d = ST_ISSUE;
               load    = 1'b1;
               if (grant_vec[KIND_LONG]) begin
                  kind_d   = CMD_ZQ_LONG;
                  load_val = CNT_W'(LONG_ZQ_CLKS - 1);
               end else begin
                  kind_d   = CMD_ZQ_SHORT;
                  load_val = CNT_W'(SHORT_ZQ_CLKS - 1);
               end
            end
            default: state_d = ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         state  <= ST_HOLD;
         kind   <= CMD_NOP;
         done_q <= 1'b0;
      end else begin
         state  <= state_d;
         kind   <= kind_d;
         done_q <= done_d;
      end
   end

   assign dram_rst_n = (state != ST_HOLD);
   assign cal_cmd    = (state == ST_ISSUE) ? kind : CMD_NOP;
   assign cal_busy   = (state == ST_ISSUE) || (state == ST_CAL);
   assign init_done  = done_q;

   // R1: while reset is driven nothing else is active
   a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
      !dram_rst_n |-> (cal_cmd == CMD_NOP && !cal_busy && !init_done));

   // R2: release of reset is accompanied by the long command
   a_r2_first_cmd_long: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(dram_rst_n) |-> (cal_cmd == CMD_ZQ_LONG));

   // R2: a command lasts one cycle
   a_r2_cmd_single: assert property (@(posedge clk) disable iff (!pwr_good)
      (cal_cmd != CMD_NOP) |=> (cal_cmd == CMD_NOP));

   // R3: init_done rises only as a window closes
   a_r3_done_after_window: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(init_done) |-> (!cal_busy && $past(cal_busy)));

   // R9: post-init commands need idle at the issuing edge
   a_r9_idle_gate: assert property (@(posedge clk) disable iff (!pwr_good)
      (cal_cmd != CMD_NOP && init_done) |-> $past(dram_idle));

   // R8: a pending long request wins when a slot opens
   a_r8_long_first: assert property (@(posedge clk) disable iff (!pwr_good)
      (state == ST_READY && pend[KIND_LONG] && dram_idle && !warm_go)
      |=> (cal_cmd == CMD_ZQ_LONG));

endmodule

// File: tb/dram_rstcal_seq_bench.sv
module dram_rstcal_seq_bench;

   localparam int P_PWR   = 40;
   localparam int P_WARM  = 6;
   localparam int P_INIT  = 24;
   localparam int P_LONG  = 12;
   localparam int P_SHORT = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       pwr_good, warm_rst_req, dram_idle, zq_long_req, zq_short_req;
   logic [1:0] cal_cmd;
   logic       dram_rst_n, cal_busy, init_done;

   int checks = 0;
   int fails  = 0;

   dram_rstcal_seq #(
      .PWR_HOLD_CLKS (P_PWR),
      .WARM_HOLD_CLKS(P_WARM),
      .INIT_ZQ_CLKS  (P_INIT),
      .LONG_ZQ_CLKS  (P_LONG),
      .SHORT_ZQ_CLKS (P_SHORT)
   ) u_dram_rstcal_seq (
      .clk         (clk),
      .pwr_good    (pwr_good),
      .warm_rst_req(warm_rst_req),
      .dram_idle   (dram_idle),
      .zq_long_req (zq_long_req),
      .zq_short_req(zq_short_req),
      .cal_cmd     (cal_cmd),
      .dram_rst_n  (dram_rst_n),
      .cal_busy    (cal_busy),
      .init_done   (init_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called in the command cycle; returns at the first cycle with busy low
   task automatic window(input int kind, input int len, input string tag);
      int m = 1;
      int extra = 0;
      chk(cal_cmd == 2'(kind), {tag, " command code"}, cal_cmd, kind);
      while (m < 1000) begin
         @(negedge clk);
         if (!cal_busy) break;
         m++;
         if (cal_cmd != 2'b00) extra++;
      end
      chk(m == len, {tag, " busy length"}, m, len);
      chk(extra == 0, {tag, " extra command in window"}, extra, 0);
   endtask

   task automatic wait_cmd(output int n);
      n = 1;
      while (cal_cmd == 2'b00 && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset_state;
      pwr_good = 1'b0;
      repeat (3) @(negedge clk);
      chk(dram_rst_n == 1'b0, "R1 reset dram_rst_n", dram_rst_n, 0);
      chk(cal_busy == 1'b0, "R1 reset busy", cal_busy, 0);
      chk(cal_cmd == 2'b00, "R1 reset cmd", cal_cmd, 0);
      chk(init_done == 1'b0, "R1 reset init_done", init_done, 0);
   endtask

   task automatic t_power_up;
      int n = 0;
      int m = 1;
      int lows = 0;
      int early = 0;
      int cmds = 0;
      pwr_good = 1'b1;
      while (n < 1000) begin
         @(negedge clk);
         n++;
         if (dram_rst_n) break;
      end
      chk(n == P_PWR, "R1 power-up hold edges", n, P_PWR);
      chk(cal_cmd == 2'b01, "R2 init long code", cal_cmd, 1);
      while (m < 1000) begin
         if (m == 3) begin
            zq_long_req = 1'b1; zq_short_req = 1'b1; warm_rst_req = 1'b1;
         end
         @(negedge clk);
         zq_long_req = 1'b0; zq_short_req = 1'b0; warm_rst_req = 1'b0;
         if (!dram_rst_n) lows++;
         if (!cal_busy) break;
         if (init_done) early++;
         m++;
      end
      chk(m == P_INIT, "R2 init window length", m, P_INIT);
      chk(lows == 0, "R11 warm request during init ignored", lows, 0);
      chk(early == 0, "R3 init_done low inside window", early, 0);
      chk(init_done == 1'b1, "R3 init_done after window", init_done, 1);
      repeat (10) begin
         @(negedge clk);
         if (cal_cmd != 2'b00) cmds++;
      end
      chk(cmds == 0, "R4 early requests discarded", cmds, 0);
   endtask

   task automatic t_short;
      int n;
      zq_short_req = 1'b1;
      @(negedge clk);
      zq_short_req = 1'b0;
      wait_cmd(n);
      chk(n == 2, "R5 short latency", n, 2);
      window(2, P_SHORT, "R5 short");
   endtask

   task automatic t_long;
      int n;
      zq_long_req = 1'b1;
      @(negedge clk);
      zq_long_req = 1'b0;
      wait_cmd(n);
      chk(n == 2, "R6 long latency", n, 2);
      window(1, P_LONG, "R6 long");
   endtask

   task automatic t_queue_idle;
      int cmds = 0;
      dram_idle = 1'b0;
      zq_short_req = 1'b1;
      @(negedge clk);
      zq_short_req = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (cal_cmd != 2'b00) cmds++;
      end
      chk(cmds == 0, "R9 no command while not idle", cmds, 0);
      dram_idle = 1'b1;
      @(negedge clk);
      chk(cal_cmd == 2'b10, "R7 queued short after idle", cal_cmd, 2);
      window(2, P_SHORT, "R7 queued short");
   endtask

   task automatic t_priority;
      dram_idle = 1'b0;
      zq_short_req = 1'b1;
      zq_long_req  = 1'b1;
      @(negedge clk);
      zq_short_req = 1'b0;
      zq_long_req  = 1'b0;
      @(negedge clk);
      dram_idle = 1'b1;
      @(negedge clk);
      chk(cal_cmd == 2'b01, "R8 long first", cal_cmd, 1);
      window(1, P_LONG, "R8 long");
      chk(cal_cmd == 2'b00, "R8 gap cycle", cal_cmd, 0);
      @(negedge clk);
      chk(cal_cmd == 2'b10, "R8 short follows", cal_cmd, 2);
      window(2, P_SHORT, "R8 short");
   endtask

   task automatic t_warm;
      int n = 1;
      int cmds = 0;
      dram_idle = 1'b0;
      zq_short_req = 1'b1;
      @(negedge clk);
      zq_short_req = 1'b0;
      warm_rst_req = 1'b1;
      @(negedge clk);
      warm_rst_req = 1'b0;
      chk(dram_rst_n == 1'b0, "R10 reset asserted", dram_rst_n, 0);
      chk(init_done == 1'b0, "R10 init_done cleared", init_done, 0);
      while (!dram_rst_n && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n - 1 == P_WARM, "R10 warm hold length", n - 1, P_WARM);
      dram_idle = 1'b1;
      window(1, P_INIT, "R10 re-init");
      chk(init_done == 1'b1, "R10 init_done again", init_done, 1);
      repeat (10) begin
         @(negedge clk);
         if (cal_cmd != 2'b00) cmds++;
      end
      chk(cmds == 0, "R10 pending flushed", cmds, 0);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      pwr_good = 1'b0; warm_rst_req = 1'b0; dram_idle = 1'b1;
      zq_long_req = 1'b0; zq_short_req = 1'b0;
      t_reset_state();
      t_power_up();
      t_short();
      t_long();
      t_queue_idle();
      t_priority();
      t_warm();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule